// File: doc/BRIEF.md
# JTAG Debug Port with CPU-Visible Scan Registers

This block is a serial debug port driven by the standard five test pins. An IEEE 1149.1 TAP state machine steps the scan sequence on the test clock. Three scan paths sit between the serial input and the serial output: a 16-bit instruction register, a 16-bit status register that the TAP can only read, and a 32-bit data register kept as a high half and a low half. Any unassigned instruction selects a one-bit bypass path. The same registers are visible to a small CPU bus port. That port takes byte, halfword and word accesses at fixed byte offsets, and each register has its own access rights.

The CPU port is sampled on the rising edge of the test clock, so both sides share one clock domain. Writes from the CPU and updates from the TAP therefore meet in the same register stage, and a fixed priority settles any conflict between them. Only the test reset pin, or the TAP's own reset state for the instruction register, initializes these registers. System resets do not reach this block.

Top module: `jtag_dbg_port`

## Requirements
- R1: While trstN is low, the TAP is held in Test-Logic-Reset. The instruction register reads 0xF000, the status register reads 0x0201, tdoOe is 0 and tdo is 1. The data halves keep no defined value.
- R2: Five rising tck edges with tms high bring the TAP to Test-Logic-Reset from any state. The next rising edge in that state sets the instruction register to 0xF000 and leaves the status and data registers unchanged.
- R3: Capture-IR loads the present instruction into the IR shift path. Shift-IR moves it out on tdo LSB first while tdi enters at the MSB end. Update-IR copies the 16 shifted bits into the instruction register.
- R4: Instruction 0x5000 selects the status path. Capture-DR loads the status register, and the path is 16 bits long, LSB first. Update-DR does not change the status register.
- R5: Instruction 0xA000 selects the 32-bit data path. The high half is shifted out before the low half, each LSB first. Update-DR loads the first 16 shifted-in bits into the high half and the next 16 into the low half.
- R6: Every other instruction, including 0xFFFF and the reset value 0xF000, selects a one-bit bypass. Bypass captures 0, and tdi appears on tdo one tck later.
- R7: tdo and tdoOe change only on the falling edge of tck. tdoOe is 1 only while the TAP is in Shift-IR or Shift-DR. Otherwise tdo is held at 1.
- R8: CPU reads are combinational. The 8-byte map is big-endian: instruction at offset 0, status at 2, data high at 4, data low at 6. cpuSize 0, 1 and 2 select 1, 2 and 4 bytes. Address bits below the access size are ignored. The result is right-justified in cpuRdata with the upper bits zero.
- R9: A CPU write (cpuSel and cpuWr) takes effect on the rising tck edge and changes only the addressed bytes. Bytes of the instruction register are never written. A word write at offset 4 updates both data halves in one cycle.
- R10: When Update-DR on the data path and a CPU write to a data half fall on the same edge, the TAP value is stored. A CPU write to the status register on that edge still takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock; also clocks the CPU port |
| tms | input | 1 | Test mode select |
| tdi | input | 1 | Serial data in |
| trstN | input | 1 | Asynchronous test reset, active low |
| tdo | output | 1 | Serial data out, changes on falling tck |
| tdoOe | output | 1 | High while tdo carries shift data |
| cpuSel | input | 1 | CPU access valid |
| cpuWr | input | 1 | 1 = write, 0 = read |
| cpuAddr | input | 3 | Byte offset within the register block |
| cpuSize | input | 2 | 0 byte, 1 halfword, 2 word |
| cpuWdata | input | 32 | Write data, right-justified |
| cpuRdata | output | 32 | Read data, right-justified |

## Verification
The bench reads every offset with every access size, including misaligned addresses. A map with the wrong byte order or alignment returns swapped or shifted bytes. Each scan path is measured by its length and ordering. A status path of the wrong length shows tdi too early or too late, and a data path with the halves reversed returns them in the wrong order. One test forces Test-Logic-Reset from the middle of an instruction scan, where a design that clears the status or data registers on that reset loses their contents. Another lines up a CPU data write with Update-DR, and a design with the priority reversed stores the CPU value.

// File: rtl/jdp_pkg.sv
package jdp_pkg;

  typedef enum logic [3:0] {
    TAP_RESET,
    TAP_IDLE,
    TAP_SEL_DR,
    TAP_CAP_DR,
    TAP_SHIFT_DR,
    TAP_EXIT1_DR,
    TAP_PAUSE_DR,
    TAP_EXIT2_DR,
    TAP_UPD_DR,
    TAP_SEL_IR,
    TAP_CAP_IR,
    TAP_SHIFT_IR,
    TAP_EXIT1_IR,
    TAP_PAUSE_IR,
    TAP_EXIT2_IR,
    TAP_UPD_IR
  } tapState_e;

  typedef enum logic [1:0] {
    PATH_BYPASS,
    PATH_STATUS,
    PATH_DATA
  } scanPath_e;

  // Strobes from the TAP control to the datapath
  typedef struct packed {
    logic      inReset;
    logic      captureIr;
    logic      shiftIr;
    logic      updateIr;
    logic      captureDr;
    logic      shiftDr;
    logic      updateDr;
    scanPath_e path;
  } tapStrobe_t;

endpackage

// File: rtl/jdp_tap_ctrl.sv
module jdp_tap_ctrl
  import jdp_pkg::*;
#(
  parameter int                REG_W       = 16,
  parameter logic [REG_W-1:0]  CODE_STATUS = 16'h5000,
  parameter logic [REG_W-1:0]  CODE_DATA   = 16'hA000
) (
  input  logic             tck,
  input  logic             trstN,
  input  logic             tms,
  input  logic [REG_W-1:0] ir,
  output tapState_e        state,
  output tapStrobe_t       strb
);

  tapState_e nextState;

  always_comb begin
    unique case (state)
      TAP_RESET:    nextState = tms ? TAP_RESET    : TAP_IDLE;
      TAP_IDLE:     nextState = tms ? TAP_SEL_DR   : TAP_IDLE;
      TAP_SEL_DR:   nextState = tms ? TAP_SEL_IR   : TAP_CAP_DR;
      TAP_CAP_DR:   nextState = tms ? TAP_EXIT1_DR : TAP_SHIFT_DR;
      TAP_SHIFT_DR: nextState = tms ? TAP_EXIT1_DR : TAP_SHIFT_DR;
      TAP_EXIT1_DR: nextState = tms ? TAP_UPD_DR   : TAP_PAUSE_DR;
      TAP_PAUSE_DR: nextState = tms ? TAP_EXIT2_DR : TAP_PAUSE_DR;
      TAP_EXIT2_DR: nextState = tms ? TAP_UPD_DR   : TAP_SHIFT_DR;
      TAP_UPD_DR:   nextState = tms ? TAP_SEL_DR   : TAP_IDLE;
      TAP_SEL_IR:   nextState = tms ? TAP_RESET    : TAP_CAP_IR;
      TAP_CAP_IR:   nextState = tms ? TAP_EXIT1_IR : TAP_SHIFT_IR;
      TAP_SHIFT_IR: nextState = tms ? TAP_EXIT1_IR : TAP_SHIFT_IR;
      TAP_EXIT1_IR: nextState = tms ? TAP_UPD_IR   : TAP_PAUSE_IR;
      TAP_PAUSE_IR: nextState = tms ? TAP_EXIT2_IR : TAP_PAUSE_IR;
      TAP_EXIT2_IR: nextState = tms ? TAP_UPD_IR   : TAP_SHIFT_IR;
      TAP_UPD_IR:   nextState = tms ? TAP_SEL_DR   : TAP_IDLE;
      default:      nextState = TAP_RESET;
    endcase
  end

  always_ff @(posedge tck or negedge trstN) begin
    if (!trstN) state <= TAP_RESET;
    else        state <= nextState;
  end

  // Instruction decode: only two codes own a path, everything else bypasses
  scanPath_e pathSel;
  always_comb begin
    if (ir == CODE_DATA)        pathSel = PATH_DATA;
    else if (ir == CODE_STATUS) pathSel = PATH_STATUS;
    else                        pathSel = PATH_BYPASS;
  end

  always_comb begin
    strb.inReset   = (state == TAP_RESET);
    strb.captureIr = (state == TAP_CAP_IR);
    strb.shiftIr   = (state == TAP_SHIFT_IR);
    strb.updateIr  = (state == TAP_UPD_IR);
    strb.captureDr = (state == TAP_CAP_DR);
    strb.shiftDr   = (state == TAP_SHIFT_DR);
    strb.updateDr  = (state == TAP_UPD_DR);
    strb.path      = pathSel;
  end

endmodule

// File: rtl/jdp_datapath.sv
module jdp_datapath
  import jdp_pkg::*;
#(
  parameter int               REG_W    = 16,
  parameter logic [REG_W-1:0] IR_RESET = 16'hF000,
  parameter logic [REG_W-1:0] SR_RESET = 16'h0201,
  parameter int               ADDR_W   = 3
) (
  input  logic               tck,
  input  logic               trstN,
  input  logic               tdi,
  input  tapStrobe_t         strb,
  input  logic               cpuSel,
  input  logic               cpuWr,
  input  logic [ADDR_W-1:0]  cpuAddr,
  input  logic [1:0]         cpuSize,
  input  logic [2*REG_W-1:0] cpuWdata,
  output logic [2*REG_W-1:0] cpuRdata,
  output logic [REG_W-1:0]   irVal,
  output logic               tdo,
  output logic               tdoOe
);

  localparam int RB    = REG_W / 8;      // bytes per register
  localparam int NREG  = 4;              // instruction, status, data high, data low
  localparam int NLANE = NREG * RB;      // bytes in the CPU map
  localparam int BUS_B = 2 * RB;         // bytes in one bus word
  localparam int SH_W  = 2 * REG_W;      // longest scan path

  logic [REG_W-1:0] irReg, srReg, drHi, drLo;
  logic [REG_W-1:0] irSh;
  logic [SH_W-1:0]  drSh;

  // ---------------- CPU access geometry ----------------
  int accBytes;
  int accBase;

  always_comb begin
    case (cpuSize)
      2'd0:    accBytes = 1;
      2'd1:    accBytes = RB;
      default: accBytes = BUS_B;
    endcase
    accBase = int'(cpuAddr) & ~(accBytes - 1);
  end

  logic [REG_W-1:0] regView [NREG];
  logic [7:0]       laneByte [NLANE];
  logic [NLANE-1:0] wrLane;
  logic [7:0]       wrByte [NLANE];

  always_comb begin
    regView[0] = irReg;
    regView[1] = srReg;
    regView[2] = drHi;
    regView[3] = drLo;
  end

  // Big-endian byte image: lane 0 is the MSB of the first register
  always_comb begin
    for (int k = 0; k < NLANE; k++) begin
      laneByte[k] = regView[k / RB][REG_W - 1 - 8 * (k % RB) -: 8];
    end
  end

  always_comb begin
    for (int k = 0; k < NLANE; k++) begin
      int off;
      off = accBase + accBytes - 1 - k;
      wrLane[k] = cpuSel && cpuWr && (k >= accBase) && (k < accBase + accBytes);
      if (off < 0 || off >= BUS_B) off = 0;
      wrByte[k] = cpuWdata[8 * off +: 8];
    end
  end

  always_comb begin
    cpuRdata = '0;
    for (int m = 0; m < BUS_B; m++) begin
      if (m < accBytes && accBase + m < NLANE)
        cpuRdata[8 * (accBytes - 1 - m) +: 8] = laneByte[accBase + m];
    end
  end

  // Merged CPU write values; instruction lanes are never merged
  logic [REG_W-1:0] srNext, drHiNext, drLoNext;

  always_comb begin
    srNext   = srReg;
    drHiNext = drHi;
    drLoNext = drLo;
    for (int j = 0; j < RB; j++) begin
      if (wrLane[1 * RB + j]) srNext[REG_W - 1 - 8 * j -: 8]   = wrByte[1 * RB + j];
      if (wrLane[2 * RB + j]) drHiNext[REG_W - 1 - 8 * j -: 8] = wrByte[2 * RB + j];
      if (wrLane[3 * RB + j]) drLoNext[REG_W - 1 - 8 * j -: 8] = wrByte[3 * RB + j];
    end
  end

  // ---------------- Architectural registers ----------------
  always_ff @(posedge tck or negedge trstN) begin
    if (!trstN)             irReg <= IR_RESET;
    else if (strb.inReset)  irReg <= IR_RESET;
    else if (strb.updateIr) irReg <= irSh;
  end

  always_ff @(posedge tck or negedge trstN) begin
    if (!trstN) srReg <= SR_RESET;
    else        srReg <= srNext;
  end

  // Data halves carry no reset; a TAP update outranks the CPU
  always_ff @(posedge tck) begin
    if (strb.updateDr && strb.path == PATH_DATA) begin
      drHi <= drSh[REG_W-1:0];
      drLo <= drSh[SH_W-1:REG_W];
    end else begin
      drHi <= drHiNext;
      drLo <= drLoNext;
    end
  end

  // ---------------- Scan paths ----------------
  always_ff @(posedge tck or negedge trstN) begin
    if (!trstN)              irSh <= '0;
    else if (strb.captureIr) irSh <= irReg;
    else if (strb.shiftIr)   irSh <= {tdi, irSh[REG_W-1:1]};
  end

  always_ff @(posedge tck or negedge trstN) begin
    if (!trstN) begin
      drSh <= '0;
    end else if (strb.captureDr) begin
      case (strb.path)
        PATH_DATA:   drSh <= {drLo, drHi};
        PATH_STATUS: drSh <= {{REG_W{1'b0}}, srReg};
        default:     drSh <= '0;
      endcase
    end else if (strb.shiftDr) begin
      case (strb.path)
        PATH_DATA:   drSh <= {tdi, drSh[SH_W-1:1]};
        PATH_STATUS: drSh <= {{REG_W{1'b0}}, tdi, drSh[REG_W-1:1]};
        default:     drSh <= {{(SH_W-1){1'b0}}, tdi};
      endcase
    end
  end

  // Serial output is launched on the falling edge
  always_ff @(negedge tck or negedge trstN) begin
    if (!trstN) begin
      tdo   <= 1'b1;
      tdoOe <= 1'b0;
    end else if (strb.shiftIr) begin
      tdo   <= irSh[0];
      tdoOe <= 1'b1;
    end else if (strb.shiftDr) begin
      tdo   <= drSh[0];
      tdoOe <= 1'b1;
    end else begin
      tdo   <= 1'b1;
      tdoOe <= 1'b0;
    end
  end

  assign irVal = irReg;

endmodule

// File: rtl/jtag_dbg_port.sv
module jtag_dbg_port
  import jdp_pkg::*;
#(
  parameter int                REG_W       = 16,
  parameter logic [REG_W-1:0]  IR_RESET    = 16'hF000,
  parameter logic [REG_W-1:0]  SR_RESET    = 16'h0201,
  parameter logic [REG_W-1:0]  CODE_STATUS = 16'h5000,
  parameter logic [REG_W-1:0]  CODE_DATA   = 16'hA000,
  localparam int               ADDR_W      = $clog2(4 * REG_W / 8),
  localparam int               BUS_W       = 2 * REG_W
) (
  input  logic              tck,
  input  logic              tms,
  input  logic              tdi,
  input  logic              trstN,
  output logic              tdo,
  output logic              tdoOe,
  input  logic              cpuSel,
  input  logic              cpuWr,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic [1:0]        cpuSize,
  input  logic [BUS_W-1:0]  cpuWdata,
  output logic [BUS_W-1:0]  cpuRdata
);

  tapState_e        state;
  tapStrobe_t       strb;
  logic [REG_W-1:0] irVal;

  jdp_tap_ctrl #(
    .REG_W      (REG_W),
    .CODE_STATUS(CODE_STATUS),
    .CODE_DATA  (CODE_DATA)
  ) uCtrl (
    .tck  (tck),
    .trstN(trstN),
    .tms  (tms),
    .ir   (irVal),
    .state(state),
    .strb (strb)
  );

  jdp_datapath #(
    .REG_W   (REG_W),
    .IR_RESET(IR_RESET),
    .SR_RESET(SR_RESET),
    .ADDR_W  (ADDR_W)
  ) uData (
    .tck     (tck),
    .trstN   (trstN),
    .tdi     (tdi),
    .strb    (strb),
    .cpuSel  (cpuSel),
    .cpuWr   (cpuWr),
    .cpuAddr (cpuAddr),
    .cpuSize (cpuSize),
    .cpuWdata(cpuWdata),
    .cpuRdata(cpuRdata),
    .irVal   (irVal),
    .tdo     (tdo),
    .tdoOe   (tdoOe)
  );

endmodule

// File: rtl/jdp_checker.sv
module jdp_checker
  import jdp_pkg::*;
#(
  parameter int               REG_W    = 16,
  parameter logic [REG_W-1:0] IR_RESET = 16'hF000,
  parameter int               ADDR_W   = 3
) (
  input logic               tck,
  input logic               trstN,
  input logic               tms,
  input logic               tdo,
  input logic               tdoOe,
  input tapState_e          state,
  input tapStrobe_t         strb,
  input logic [REG_W-1:0]   irVal,
  input logic               cpuSel,
  input logic               cpuWr,
  input logic [ADDR_W-1:0]  cpuAddr,
  input logic [1:0]         cpuSize,
  input logic [2*REG_W-1:0] cpuRdata
);

  // Count of consecutive rising edges with tms high (saturating)
  logic [2:0] tmsRun;
  always_ff @(posedge tck or negedge trstN) begin
    if (!trstN)               tmsRun <= '0;
    else if (!tms)            tmsRun <= '0;
    else if (tmsRun != 3'd7)  tmsRun <= tmsRun + 3'd1;
  end

  assert_trst_hold_R1: assert property (@(posedge tck)
    !trstN |-> (state == TAP_RESET && irVal == IR_RESET && !tdoOe));

  assert_tms_reset_R2: assert property (@(posedge tck) disable iff (!trstN)
    (tmsRun >= 3'd5) |-> (state == TAP_RESET));

  assert_oe_in_shift_R7: assert property (@(posedge tck) disable iff (!trstN)
    tdoOe |-> (state == TAP_SHIFT_IR || state == TAP_SHIFT_DR));

  assert_tdo_idle_R7: assert property (@(posedge tck) disable iff (!trstN)
    !tdoOe |-> tdo);

  assert_ir_cpu_ro_R9: assert property (@(posedge tck) disable iff (!trstN)
    !(strb.updateIr || strb.inReset) |=> $stable(irVal));

  assert_ir_read_R8: assert property (@(posedge tck) disable iff (!trstN)
    (cpuSel && !cpuWr && cpuAddr == '0 && cpuSize == 2'd1)
      |-> (cpuRdata == {{REG_W{1'b0}}, irVal}));

endmodule

bind jtag_dbg_port jdp_checker #(
  .REG_W   (REG_W),
  .IR_RESET(IR_RESET),
  .ADDR_W  (ADDR_W)
) uChk (
  .tck     (tck),
  .trstN   (trstN),
  .tms     (tms),
  .tdo     (tdo),
  .tdoOe   (tdoOe),
  .state   (state),
  .strb    (strb),
  .irVal   (irVal),
  .cpuSel  (cpuSel),
  .cpuWr   (cpuWr),
  .cpuAddr (cpuAddr),
  .cpuSize (cpuSize),
  .cpuRdata(cpuRdata)
);

// File: tb/tb_jtag_dbg_port.sv
module tb_jtag_dbg_port;

  localparam int CLK_PERIOD = 20;

  logic        tck = 1'b0;
  logic        tms = 1'b1;
  logic        tdi = 1'b0;
  logic        trstN = 1'b1;
  logic        cpuSel = 1'b0;
  logic        cpuWr = 1'b0;
  logic [2:0]  cpuAddr = '0;
  logic [1:0]  cpuSize = '0;
  logic [31:0] cpuWdata = '0;
  logic        tdo, tdoOe;
  logic [31:0] cpuRdata;

  int nChecks = 0;
  int nFails  = 0;

  // Bench model of the four registers
  logic [15:0] mIr, mSr, mDh, mDl;

  jtag_dbg_port dut (
    .tck(tck), .tms(tms), .tdi(tdi), .trstN(trstN),
    .tdo(tdo), .tdoOe(tdoOe),
    .cpuSel(cpuSel), .cpuWr(cpuWr), .cpuAddr(cpuAddr), .cpuSize(cpuSize),
    .cpuWdata(cpuWdata), .cpuRdata(cpuRdata)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp,
                       input string what);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // One tck cycle; tdo is sampled before the rising edge and again while tck is high
  task automatic tick(input logic tmsV, input logic tdiV, output logic tdoS, output logic oeS);
    logic hi;
    tms = tmsV;
    tdi = tdiV;
    #(CLK_PERIOD/4);
    tdoS = tdo;
    oeS  = tdoOe;
    #(CLK_PERIOD/4);
    tck = 1'b1;
    #(CLK_PERIOD/4);
    hi = tdo;
    #(CLK_PERIOD/4);
    tck = 1'b0;
    check("R7", {31'b0, hi}, {31'b0, tdoS}, "tdo moved while tck high");
  endtask

  task automatic tk(input logic v);
    logic a, b;
    tick(v, 1'b0, a, b);
  endtask

  function automatic int sizeBytes(input int size);
    return (size == 0) ? 1 : (size == 1) ? 2 : 4;
  endfunction

  function automatic logic [31:0] expRead(input int addr, input int size);
    logic [63:0] img;
    logic [31:0] r;
    int n, base;
    n = sizeBytes(size);
    base = addr & ~(n - 1);
    img = {mIr, mSr, mDh, mDl};
    r = '0;
    for (int m = 0; m < n; m++) r[8*(n-1-m) +: 8] = img[63 - 8*(base+m) -: 8];
    return r;
  endfunction

  task automatic modelWrite(input int addr, input int size, input logic [31:0] d);
    logic [63:0] img;
    int n, base;
    n = sizeBytes(size);
    base = addr & ~(n - 1);
    img = {mIr, mSr, mDh, mDl};
    for (int m = 0; m < n; m++)
      if (base + m >= 2) img[63 - 8*(base+m) -: 8] = d[8*(n-1-m) +: 8];
    {mIr, mSr, mDh, mDl} = img;
  endtask

  task automatic cpuWrite(input int addr, input int size, input logic [31:0] d);
    cpuSel = 1'b1; cpuWr = 1'b1;
    cpuAddr = 3'(addr); cpuSize = 2'(size); cpuWdata = d;
    tk(1'b0);
    cpuSel = 1'b0; cpuWr = 1'b0;
    modelWrite(addr, size, d);
  endtask

  task automatic cpuCheck(input string req, input int addr, input int size);
    cpuSel = 1'b1; cpuWr = 1'b0;
    cpuAddr = 3'(addr); cpuSize = 2'(size);
    #1;
    check(req, cpuRdata, expRead(addr, size), $sformatf("read addr %0d size %0d", addr, size));
    cpuSel = 1'b0;
  endtask

  // From Run-Test/Idle: instruction scan, back to Idle
  task automatic scanIr(input logic [15:0] din, output logic [15:0] dout);
    logic b, oe;
    tk(1'b1); tk(1'b1); tk(1'b0); tk(1'b0);
    for (int i = 0; i < 16; i++) begin
      tick(i == 15, din[i], b, oe);
      dout[i] = b;
      if (i == 0) check("R7", {31'b0, oe}, 32'd1, "tdoOe in Shift-IR");
    end
    tk(1'b1); tk(1'b0);
  endtask

  // From Run-Test/Idle: data scan of n bits; optionally stop in Update-DR
  task automatic scanDr(input int n, input logic [31:0] din, output logic [31:0] dout,
                        input bit stopAtUpdate);
    logic b, oe;
    dout = '0;
    tk(1'b1); tk(1'b0); tk(1'b0);
    for (int i = 0; i < n; i++) begin
      tick(i == n - 1, din[i], b, oe);
      dout[i] = b;
    end
    tk(1'b1);
    if (!stopAtUpdate) tk(1'b0);
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 200000);
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin : main
    logic [15:0] irOut;
    logic [31:0] drOut, din;
    logic [15:0] codes [4];

    // ---- R1: test reset ----
    #(CLK_PERIOD/2);
    trstN = 1'b0;
    #(CLK_PERIOD/4);
    tk(1'b0); tk(1'b1);
    check("R1", {31'b0, tdoOe}, 32'd0, "tdoOe during reset");
    check("R1", {31'b0, tdo}, 32'd1, "tdo during reset");
    trstN = 1'b1;
    mIr = 16'hF000; mSr = 16'h0201; mDh = '0; mDl = '0;
    cpuCheck("R1", 0, 1);
    cpuCheck("R1", 2, 1);
    tk(1'b0);  // to Run-Test/Idle

    // ---- R9: CPU writes ----
    cpuWrite(4, 2, 32'h1234_5678);
    cpuCheck("R9", 4, 1);
    cpuCheck("R9", 6, 1);
    cpuWrite(2, 1, 32'h0000_A55A);
    cpuCheck("R9", 2, 1);
    cpuWrite(0, 1, 32'h0000_0BAD);
    cpuCheck("R9", 0, 1);
    cpuWrite(1, 2, 32'h1111_C3C3);
    cpuCheck("R9", 0, 2);
    for (int k = 0; k < 8; k++) cpuWrite(k, 0, 32'h40 + k);
    cpuCheck("R9", 0, 2);
    cpuCheck("R9", 4, 2);

    // ---- R8: read sweep over every offset and size ----
    for (int s = 0; s < 3; s++)
      for (int a = 0; a < 8; a++) cpuCheck("R8", a, s);

    // ---- R3 / R5: data path ----
    scanIr(16'hA000, irOut);
    check("R3", {16'b0, irOut}, {16'b0, mIr}, "IR capture");
    mIr = 16'hA000;
    cpuCheck("R3", 0, 1);
    begin
      logic [31:0] pats [3];
      pats[0] = 32'h9C3E_71A5; pats[1] = 32'h0000_FFFF; pats[2] = 32'h8000_0001;
      for (int p = 0; p < 3; p++) begin
        scanDr(32, pats[p], drOut, 1'b0);
        check("R5", drOut, {mDl, mDh}, "data capture order");
        mDh = pats[p][15:0]; mDl = pats[p][31:16];
        cpuCheck("R5", 4, 2);
      end
    end

    // ---- R4: status path ----
    scanIr(16'h5000, irOut);
    check("R3", {16'b0, irOut}, 32'h0000_A000, "IR capture");
    mIr = 16'h5000;
    din = 32'h0000_6A5C;
    scanDr(32, din, drOut, 1'b0);
    check("R4", drOut, {din[15:0], mSr}, "status length and capture");
    cpuCheck("R4", 2, 1);
    scanDr(16, 32'h0000_FFFF, drOut, 1'b0);
    check("R4", drOut, {16'b0, mSr}, "status capture after update");

    // ---- R6: bypass for other codes ----
    codes[0] = 16'hFFFF; codes[1] = 16'h1234; codes[2] = 16'h5001; codes[3] = 16'hA001;
    for (int c = 0; c < 4; c++) begin
      scanIr(codes[c], irOut);
      check("R3", {16'b0, irOut}, {16'b0, mIr}, "IR capture");
      mIr = codes[c];
      din = 32'h0000_00B2 ^ c;
      scanDr(8, din, drOut, 1'b0);
      check("R6", drOut, {24'b0, din[6:0], 1'b0}, "bypass one-bit delay");
      cpuCheck("R6", 4, 2);
    end

    // ---- R2: five tms-high cycles from inside Shift-IR ----
    scanIr(16'hA000, irOut);
    mIr = 16'hA000;
    tk(1'b1); tk(1'b1); tk(1'b0); tk(1'b0);
    begin
      logic b, oe;
      tick(1'b0, 1'b1, b, oe);
      tick(1'b0, 1'b1, b, oe);
    end
    repeat (5) tk(1'b1);
    check("R2", {31'b0, tdoOe}, 32'd0, "tdoOe in Test-Logic-Reset");
    tk(1'b0);
    mIr = 16'hF000;
    cpuCheck("R2", 0, 1);
    cpuCheck("R2", 2, 1);
    cpuCheck("R2", 4, 2);
    din = 32'h0000_004D;
    scanDr(8, din, drOut, 1'b0);
    check("R2", drOut, {24'b0, din[6:0], 1'b0}, "bypass after TAP reset");

    // ---- R10: same-edge conflict ----
    scanIr(16'hA000, irOut);
    mIr = 16'hA000;
    din = 32'h3C5A_E718;
    scanDr(32, din, drOut, 1'b1);
    cpuSel = 1'b1; cpuWr = 1'b1; cpuAddr = 3'd4; cpuSize = 2'd2; cpuWdata = 32'hDEAD_BEEF;
    tk(1'b0);
    cpuSel = 1'b0; cpuWr = 1'b0;
    mDh = din[15:0]; mDl = din[31:16];
    cpuCheck("R10", 4, 2);
    din = 32'h0F0F_1234;
    scanDr(32, din, drOut, 1'b1);
    cpuSel = 1'b1; cpuWr = 1'b1; cpuAddr = 3'd2; cpuSize = 2'd1; cpuWdata = 32'h0000_7E81;
    tk(1'b0);
    cpuSel = 1'b0; cpuWr = 1'b0;
    mDh = din[15:0]; mDl = din[31:16]; mSr = 16'h7E81;
    cpuCheck("R10", 4, 2);
    cpuCheck("R10", 2, 1);

    // ---- R1: asynchronous reset in the middle of a scan ----
    tk(1'b1); tk(1'b0); tk(1'b0);
    begin
      logic b, oe;
      tick(1'b0, 1'b1, b, oe);
      check("R7", {31'b0, oe}, 32'd1, "tdoOe in Shift-DR");
    end
    trstN = 1'b0;
    #(CLK_PERIOD/4);
    check("R1", {31'b0, tdoOe}, 32'd0, "tdoOe after async reset");
    check("R1", {31'b0, tdo}, 32'd1, "tdo after async reset");
    trstN = 1'b1;
    mIr = 16'hF000; mSr = 16'h0201;
    cpuCheck("R1", 0, 2);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule